// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast input clock into the timing pulses a serial receiver or transmitter needs. It produces an oversampling tick and a bit-boundary strobe. The tick period comes from a divisor with a 12-bit whole part and a fractional part in steps of 1/128 of a clock. A 2-bit factor code chooses how many ticks make one bit period: 128, 64, 32 or 16. The ideal divisor is the input clock frequency divided by the product of the factor and the baud rate. The whole part must be at least one.

A phase accumulator of modulo 128 collects the fractional part once per tick. When it wraps, that tick period is one input clock longer. The accumulator starts each run at its half-way value, 64, so that truncation becomes rounding. There are two accuracy modes. In frame-accurate mode the accumulator runs freely across bit boundaries, so the length of a whole frame follows the ideal value, while single bits may differ by one clock. In bit-accurate mode the accumulator goes back to its half-way value at every bit boundary. Every bit then has the same length, the rounded value of (whole + fraction/128) × factor clocks, and the error adds up over the frame.

A frame-start pulse resynchronises all of the timing. A whole part of zero stops both outputs.

Top module: `baud_frac_gen`

## Requirements
- R1: While `rst` is high, both outputs are low. The state left by reset is the same as the state after a frame-start pulse. Timing is counted from the last clock edge at which `rst` was high.
- R2: `factor_sel` codes 0, 1, 2 and 3 give 128, 64, 32 and 16 oversample ticks per bit. `bit_strobe` rises together with every factor-th tick counted from the resync point.
- R3: In frame-accurate mode (`bit_accurate`=0), with I the whole part and F the fractional part, tick k (k ≥ 1) appears at cycle k·I + floor((64 + k·F)/128) after the resync edge.
- R4: In bit-accurate mode (`bit_accurate`=1), each bit lasts exactly L = fac·I + floor((64 + fac·F)/128) cycles, where fac is the factor. Tick j (1..fac) of bit b (b ≥ 0) appears at cycle b·L + j·I + floor((64 + j·F)/128).
- R5: A `frame_start` pulse clears the tick counter, the tick index and the accumulator. Both outputs are low in the cycle that follows it, and timing restarts from that edge.
- R6: While `int_div` is zero, neither `os_tick` nor `bit_strobe` is asserted.
- R7: Only bits [6:0] of `frac_div` are used. Bits [11:7] have no effect on the timing.
- R8: Both outputs are registered, one-cycle pulses. `bit_strobe` is never high without `os_tick`. With a whole part above one, two ticks never fall in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Resync pulse at the start of a frame |
| int_div | input | 12 | Whole part of the divisor; zero stops the outputs |
| frac_div | input | 12 | Fractional part in 1/128 steps; only bits [6:0] are used |
| factor_sel | input | 2 | Oversampling factor code (0:128, 1:64, 2:32, 3:16) |
| bit_accurate | input | 1 | 1 = equal bit lengths; 0 = frame length tracks the ideal |
| os_tick | output | 1 | Oversample tick pulse |
| bit_strobe | output | 1 | Bit-boundary pulse, coincident with the last tick of a bit |

## Verification
Random divisors with random factor codes are run in both accuracy modes. Every cycle is compared against the closed-form tick times. A wrong carry threshold or a wrong preload value moves single ticks, while a missing reload at bit boundaries only shows up after the first bit in bit-accurate mode. Directed cases cover a whole part of one, where ticks fall every cycle or every other cycle, and a fraction of 127, where almost every period is lengthened. Further directed cases cover a zero whole part, garbage in the unused fraction bits, and a resync in the middle of a bit. Together these separate errors in the tick index from errors in the accumulator.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  // fractional resolution: 1/128 of an input clock
  localparam int FRAC_W = 7;
  // tick index must hold factor-1 for the largest factor
  localparam int TIDX_W = 7;
  localparam int FAC_W  = TIDX_W + 1;

  typedef enum logic {
    ACC_FRAME = 1'b0,
    ACC_BIT   = 1'b1
  } acc_mode_e;

  function automatic logic [FAC_W-1:0] ticks_per_bit(input logic [1:0] sel);
    return FAC_W'(128) >> sel;
  endfunction
endpackage

// File: rtl/baudgen_phase.sv
// Tick period generator: whole-part counter plus modulo-128 phase accumulator.
module baudgen_phase
  import baudgen_pkg::*;
#(
  parameter int INT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac,
  input  logic              rebase,
  output logic              fire
);
  localparam int CW = INT_W + 1;
  localparam logic [FRAC_W-1:0] HALF = {1'b1, {(FRAC_W-1){1'b0}}};

  logic [CW-1:0]     cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [CW-1:0]     period;
  logic              en;

  always_comb begin
    en     = (int_div != '0);
    sum    = {1'b0, acc_q} + {1'b0, frac};
    period = {1'b0, int_div} + CW'(sum[FRAC_W]);
    fire   = en && (cnt_q == period - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      cnt_q <= '0;
      acc_q <= HALF;
    end else if (fire) begin
      cnt_q <= '0;
      acc_q <= rebase ? HALF : sum[FRAC_W-1:0];
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/baudgen_tickcount.sv
// Counts ticks within a bit and flags the last one.
module baudgen_tickcount
  import baudgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       en,
  input  logic       fire,
  input  logic [1:0] factor_sel,
  output logic       last
);
  logic [TIDX_W-1:0] tidx_q;

  always_comb last = ({1'b0, tidx_q} == ticks_per_bit(factor_sel) - FAC_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart || !en)
      tidx_q <= '0;
    else if (fire)
      tidx_q <= last ? '0 : tidx_q + TIDX_W'(1);
  end
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
  import baudgen_pkg::*;
#(
  parameter int INT_W        = 12,
  parameter int FRAC_FIELD_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic [INT_W-1:0]        int_div,
  input  logic [FRAC_FIELD_W-1:0] frac_div,
  input  logic [1:0]              factor_sel,
  input  logic                    bit_accurate,
  output logic                    os_tick,
  output logic                    bit_strobe
);
  logic      fire;
  logic      last;
  logic      rebase;
  acc_mode_e mode;

  always_comb begin
    mode   = acc_mode_e'(bit_accurate);
    rebase = (mode == ACC_BIT) && last;
  end

  baudgen_phase #(.INT_W(INT_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .restart (frame_start),
    .int_div (int_div),
    .frac    (frac_div[FRAC_W-1:0]),
    .rebase  (rebase),
    .fire    (fire)
  );

  baudgen_tickcount u_ticks (
    .clk        (clk),
    .rst        (rst),
    .restart    (frame_start),
    .en         (int_div != '0),
    .fire       (fire),
    .factor_sel (factor_sel),
    .last       (last)
  );

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      os_tick    <= 1'b0;
      bit_strobe <= 1'b0;
    end else begin
      os_tick    <= fire;
      bit_strobe <= fire && last;
    end
  end
endmodule

// File: rtl/baudgen_checker.sv
module baudgen_checker
  import baudgen_pkg::*;
#(
  parameter int INT_W        = 12,
  parameter int FRAC_FIELD_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    frame_start,
  input logic [INT_W-1:0]        int_div,
  input logic [FRAC_FIELD_W-1:0] frac_div,
  input logic [1:0]              factor_sel,
  input logic                    bit_accurate,
  input logic                    os_tick,
  input logic                    bit_strobe
);
  logic [FAC_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || frame_start || int_div == '0)
      seen_q <= '0;
    else if (os_tick)
      seen_q <= bit_strobe ? '0 : seen_q + FAC_W'(1);
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!os_tick && !bit_strobe));

  p_strobe_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> (seen_q == ticks_per_bit(factor_sel) - FAC_W'(1)));

  p_resync_r5: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (!os_tick && !bit_strobe));

  p_zero_div_r6: assert property (@(posedge clk) disable iff (rst)
    (int_div == '0) |=> !os_tick);

  p_strobe_needs_tick_r8: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> os_tick);

  p_no_adjacent_r8: assert property (@(posedge clk) disable iff (rst)
    (os_tick && int_div > INT_W'(1) && !frame_start) |=> !os_tick);
endmodule

bind baud_frac_gen baudgen_checker #(
  .INT_W(INT_W), .FRAC_FIELD_W(FRAC_FIELD_W)
) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .int_div(int_div),
  .frac_div(frac_div), .factor_sel(factor_sel), .bit_accurate(bit_accurate),
  .os_tick(os_tick), .bit_strobe(bit_strobe)
);

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [11:0] int_div = '0;
  logic [11:0] frac_div = '0;
  logic [1:0]  factor_sel = '0;
  logic        bit_accurate = 1'b0;
  logic        os_tick, bit_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  baud_frac_gen dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .int_div(int_div),
    .frac_div(frac_div), .factor_sel(factor_sel), .bit_accurate(bit_accurate),
    .os_tick(os_tick), .bit_strobe(bit_strobe)
  );

  function automatic longint tick_time(longint k, longint i, longint f,
                                       longint fac, bit bm);
    longint b, j, len;
    if (!bm) return k * i + ((64 + k * f) / 128);
    len = fac * i + ((64 + fac * f) / 128);
    b = (k - 1) / fac;
    j = k - b * fac;
    return b * len + j * i + ((64 + j * f) / 128);
  endfunction

  task automatic check(string tag, logic act, logic exp, string what, longint n);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %0b expected %0b", tag, what, n, act, exp);
    end
  endtask

  // by_reset=1 resyncs through rst (R1), otherwise through frame_start
  task automatic run(string tag, int i, int fraw, int sel, bit bm,
                     int ncyc, bit by_reset);
    longint f, fac, k, tn;
    bit et, es;
    @(negedge clk);
    int_div = 12'(i); frac_div = 12'(fraw);
    factor_sel = 2'(sel); bit_accurate = bm;
    if (by_reset) begin
      rst = 1'b1;
      repeat (3) begin
        @(posedge clk); @(negedge clk);
        check("R1", os_tick, 1'b0, "os_tick in reset", 0);
        check("R1", bit_strobe, 1'b0, "bit_strobe in reset", 0);
      end
      rst = 1'b0;
    end else begin
      frame_start = 1'b1;
      @(posedge clk); @(negedge clk);
      frame_start = 1'b0;
    end
    f = fraw & 127;
    fac = 128 >> sel;
    k = 1;
    tn = tick_time(k, i, f, fac, bm);
    for (int n = 1; n <= ncyc; n++) begin
      @(posedge clk); @(negedge clk);
      et = (i != 0) && (n == tn);
      es = et && (bm ? (((k - 1) % fac) == fac - 1) : ((k % fac) == 0));
      check(tag, os_tick, et, "os_tick", n);
      check(tag, bit_strobe, es, "bit_strobe", n);
      if (et) begin
        k++;
        tn = tick_time(k, i, f, fac, bm);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0b0d);
    // R1: reset state and timing counted from reset release
    run("R1", 3, 45, 3, 1'b0, 400, 1'b1);
    // R6: zero whole part keeps outputs quiet
    run("R6", 0, 99, 3, 1'b0, 500, 1'b0);
    // R2/R3: whole part one, ticks every cycle, factor 16
    run("R2", 1, 0, 3, 1'b0, 200, 1'b0);
    run("R3", 1, 127, 2, 1'b0, 400, 1'b0);
    // R4: fraction 127 in bit-accurate mode
    run("R4", 1, 127, 3, 1'b1, 400, 1'b0);
    run("R4", 2, 64, 1, 1'b1, 1200, 1'b0);
    // R7: unused fraction bits set must not alter timing
    run("R7", 2, 12'hF80, 3, 1'b0, 600, 1'b0);
    run("R7", 3, 12'hA95, 2, 1'b1, 800, 1'b0);
    // R5: resync in the middle of a bit, same config restarts cleanly
    run("R5", 5, 77, 3, 1'b0, 137, 1'b0);
    run("R5", 5, 77, 3, 1'b0, 900, 1'b0);
    run("R8", 2, 50, 0, 1'b0, 2000, 1'b0);
    for (int r = 0; r < 34; r++) begin
      int ri, rf, rs;
      bit rb;
      rs = int'($urandom % 4);
      ri = 1 + int'($urandom % 6);
      rf = int'($urandom % 4096);
      rb = 1'($urandom % 2);
      run(rb ? "R4" : "R3", ri, rf, rs, rb, 2500, 1'b0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule